// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block drives an eight-input successive-approximation converter through one conversion sequence at a time. A sequence begins on a one-cycle software start request or on a rising edge of a selected hardware trigger. The trigger can be one of six on-chip timer outputs or an external pin, which passes through a two-flop synchronizer first. Once a sequence is accepted, the block takes a snapshot of the channel enable mask. It then works through the enabled inputs from the lowest number to the highest. For each input it launches the converter with a start/done/data handshake and passes the result on, tagged with its channel number and a resolution flag.

All waits are counted in ticks of an internal conversion clock, which is the master clock divided by twice (prescale + 1). Each channel selection is preceded by a sample-and-hold wait. A longer startup wait comes before the first selection whenever the analog part has been powered down. That is the case once after reset, and at every sequence while sleep mode is selected. In sleep mode the converter power enable drops whenever no sequence is running. A software reset input puts the block back in its power-on state.

Top module: `adc_seq_ctrl`

## Requirements
- R1: One conversion-clock tick lasts (cfg_prescale+1)*2 master clock cycles. All startup and sample-and-hold waits are whole numbers of such ticks.
- R2: The first sequence after reset in normal mode spends (cfg_startup+1)*8 ticks waking up, and then (cfg_shtime+1) ticks of hold, before the first cv_start. The cycle count is taken from the edge that accepts the start request to the edge after which cv_start is high.
- R3: Before every channel launch the block waits (cfg_shtime+1) ticks. A later sequence in normal mode skips the startup wait, so its latency to the first cv_start is (cfg_shtime+1) ticks.
- R4: When cfg_trig_en is 0, only start_req begins a sequence. When it is 1, cfg_trig_sel values 0..5 start a sequence on the rising edge of tmr_trig[sel], which is accepted at the same edge as a start request. Value 6 selects ext_trig, which is accepted two edges later because of its synchronizer. Value 7 selects no source.
- R5: Accepting a sequence raises eoc_clear for exactly one cycle, and busy rises in that same cycle.
- R6: Only the enabled channels are converted, in ascending channel order, with one result per channel. Each launch is a single-cycle cv_start, and each res_valid follows a cv_done.
- R7: A start request or trigger that arrives while busy is high is ignored. It produces no eoc_clear and no extra results.
- R8: When cfg_low_res is 1 at acceptance, res_data is {2'b00, cv_data[9:2]} and res_low_res is 1. When cfg_low_res is 0, res_data equals cv_data and res_low_res is 0.
- R9: When cfg_sleep is 1, powered is 0 while idle and every sequence repeats the startup wait. When cfg_sleep is 0, powered stays 1. The first sequence after leaving sleep repeats the startup wait.
- R10: A one-cycle soft_reset aborts a running sequence (busy is 0 in the next cycle). It also forgets the warm-up, so the next sequence repeats the startup wait.
- R11: After reset, busy, cv_start, res_valid and eoc_clear are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| soft_reset | input | 1 | One-cycle synchronous reset of all sequencer state |
| start_req | input | 1 | One-cycle software request to begin a sequence |
| cfg_trig_en | input | 1 | Enables the hardware trigger path |
| cfg_trig_sel | input | 3 | Trigger source: 0..5 timer, 6 external, 7 none |
| cfg_low_res | input | 1 | 1 selects 8-bit results, 0 selects 10-bit |
| cfg_sleep | input | 1 | 1 powers the converter down between sequences |
| cfg_prescale | input | 6 | Conversion-clock divider setting |
| cfg_startup | input | 5 | Startup wait setting, in units of 8 ticks |
| cfg_shtime | input | 4 | Sample-and-hold wait setting, in ticks |
| ch_enable | input | 8 | Channel enable mask, one bit per input |
| tmr_trig | input | 6 | Timer trigger outputs, synchronous to clk |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| cv_done | input | 1 | Converter reports end of conversion |
| cv_data | input | 10 | Converter result, valid with cv_done |
| cv_start | output | 1 | One-cycle launch of a conversion |
| cv_chan | output | 3 | Channel selected at the converter input |
| res_valid | output | 1 | One-cycle strobe for a delivered result |
| res_chan | output | 3 | Channel number of the delivered result |
| res_data | output | 10 | Delivered result, right-aligned |
| res_low_res | output | 1 | Result was produced in 8-bit mode |
| eoc_clear | output | 1 | Pulse telling the status logic to clear end-of-conversion flags |
| busy | output | 1 | A sequence is in progress |
| powered | output | 1 | Converter power enable |

## Verification
The main sequence is run with a table of configurations. The table varies the prescale, startup and hold settings, so that the measured launch latency tells apart the tick length (R1), a wait that includes startup, and a wait that has only the hold. The enable masks cover a single low channel, a single top channel, a sparse mask and all eight channels, which shows whether the block skips disabled inputs and keeps ascending order. Both resolutions are used, so that truncation is distinguished from pass-through. Alternating sleep and normal rows show whether the startup wait is repeated at the right times. Directed runs then compare timer, external and absent trigger sources, a start request while busy, and a software reset in the middle of a sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAKE   = 3'd1,
    ST_HOLD   = 3'd2,
    ST_LAUNCH = 3'd3,
    ST_WAIT   = 3'd4
  } seq_state_e;

  localparam int unsigned LOW_DROP = 2;

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  localparam int unsigned CNT_W = PRE_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;

  // (prescale+1)*2 - 1 == 2*prescale + 1
  assign last_cnt = {prescale, 1'b1};
  assign tick     = run && (cnt_q == last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (srst || !run || tick) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_trig_pick.sv
module adc_trig_pick #(
  parameter int unsigned N_TMR = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             trig_en,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [N_TMR-1:0] tmr_trig,
  input  logic             ext_trig,
  output logic             fire
);
  localparam int unsigned N_SRC = 1 << SEL_W;

  logic             ext_s1_q, ext_s2_q;
  logic             prev_q;
  logic [N_SRC-1:0] src_vec;
  logic             src;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i < N_TMR) begin : g_tmr
      assign src_vec[i] = tmr_trig[i];
    end else if (i == N_TMR) begin : g_ext
      assign src_vec[i] = ext_s2_q;
    end else begin : g_none
      assign src_vec[i] = 1'b0;
    end
  end

  assign src  = src_vec[trig_sel];
  assign fire = trig_en && src && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1_q <= 1'b0;
      ext_s2_q <= 1'b0;
      prev_q   <= 1'b0;
    end else if (srst) begin
      ext_s1_q <= 1'b0;
      ext_s2_q <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      ext_s1_q <= ext_trig;
      ext_s2_q <= ext_s1_q;
      prev_q   <= src;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned SU_W   = 5,
  parameter int unsigned SH_W   = 4,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              go,
  input  logic              tick,
  input  logic              cfg_sleep,
  input  logic              cfg_low_res,
  input  logic [SU_W-1:0]   cfg_startup,
  input  logic [SH_W-1:0]   cfg_shtime,
  input  logic [N_CH-1:0]   ch_enable,
  input  logic              cv_done,
  input  logic [DATA_W-1:0] cv_data,
  output logic              run,
  output logic              cv_start,
  output logic [CH_W-1:0]   cv_chan,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [DATA_W-1:0] res_data,
  output logic              res_low_res,
  output logic              eoc_clear,
  output logic              busy,
  output logic              powered
);
  localparam int unsigned WAIT_W = ((SU_W + 3) > SH_W) ? (SU_W + 3) : SH_W;

  seq_state_e        state_q, state_d;
  logic [N_CH-1:0]   pend_q, pend_d, pend_nx;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              warm_q, warm_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic              lr_q, lr_d;
  logic              resv_q, resv_d;
  logic [CH_W-1:0]   rch_q, rch_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rlr_q, rlr_d;
  logic              eoc_q, eoc_d;
  logic [WAIT_W-1:0] wake_last, hold_last;

  function automatic logic [CH_W-1:0] lowest(input logic [N_CH-1:0] m);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (m[i]) idx = CH_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [DATA_W-1:0] shape(input logic [DATA_W-1:0] v, input logic low);
    return low ? (v >> LOW_DROP) : v;
  endfunction

  // (startup+1)*8 - 1 == 8*startup + 7
  assign wake_last = WAIT_W'({cfg_startup, 3'b111});
  assign hold_last = WAIT_W'(cfg_shtime);
  assign pend_nx   = pend_q & ~(N_CH'(1) << chan_q);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    chan_d  = chan_q;
    warm_d  = warm_q;
    wcnt_d  = wcnt_q;
    lr_d    = lr_q;
    resv_d  = 1'b0;
    rch_d   = rch_q;
    rdat_d  = rdat_q;
    rlr_d   = rlr_q;
    eoc_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cfg_sleep) warm_d = 1'b0;
        if (go) begin
          eoc_d = 1'b1;
          if (|ch_enable) begin
            pend_d  = ch_enable;
            chan_d  = lowest(ch_enable);
            lr_d    = cfg_low_res;
            wcnt_d  = '0;
            state_d = (cfg_sleep || !warm_q) ? ST_WAKE : ST_HOLD;
          end
        end
      end
      ST_WAKE: begin
        if (tick) begin
          if (wcnt_q == wake_last) begin
            wcnt_d  = '0;
            warm_d  = 1'b1;
            state_d = ST_HOLD;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          if (wcnt_q == hold_last) begin
            wcnt_d  = '0;
            state_d = ST_LAUNCH;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      ST_LAUNCH: state_d = ST_WAIT;
      ST_WAIT: begin
        if (cv_done) begin
          resv_d = 1'b1;
          rch_d  = chan_q;
          rdat_d = shape(cv_data, lr_q);
          rlr_d  = lr_q;
          pend_d = pend_nx;
          if (pend_nx == '0) begin
            state_d = ST_IDLE;
          end else begin
            chan_d  = lowest(pend_nx);
            state_d = ST_HOLD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (srst) begin
      state_d = ST_IDLE;
      pend_d  = '0;
      chan_d  = '0;
      warm_d  = 1'b0;
      wcnt_d  = '0;
      lr_d    = 1'b0;
      resv_d  = 1'b0;
      rch_d   = '0;
      rdat_d  = '0;
      rlr_d   = 1'b0;
      eoc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      chan_q  <= '0;
      warm_q  <= 1'b0;
      wcnt_q  <= '0;
      lr_q    <= 1'b0;
      resv_q  <= 1'b0;
      rch_q   <= '0;
      rdat_q  <= '0;
      rlr_q   <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      chan_q  <= chan_d;
      warm_q  <= warm_d;
      wcnt_q  <= wcnt_d;
      lr_q    <= lr_d;
      resv_q  <= resv_d;
      rch_q   <= rch_d;
      rdat_q  <= rdat_d;
      rlr_q   <= rlr_d;
      eoc_q   <= eoc_d;
    end
  end

  assign run         = (state_q == ST_WAKE) || (state_q == ST_HOLD);
  assign cv_start    = (state_q == ST_LAUNCH);
  assign cv_chan     = chan_q;
  assign res_valid   = resv_q;
  assign res_chan    = rch_q;
  assign res_data    = rdat_q;
  assign res_low_res = rlr_q;
  assign eoc_clear   = eoc_q;
  assign busy        = (state_q != ST_IDLE);
  assign powered     = !(cfg_sleep && (state_q == ST_IDLE));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned N_TMR  = 6,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned PRE_W  = 6,
  parameter int unsigned SU_W   = 5,
  parameter int unsigned SH_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_reset,
  input  logic                     start_req,
  input  logic                     cfg_trig_en,
  input  logic [SEL_W-1:0]         cfg_trig_sel,
  input  logic                     cfg_low_res,
  input  logic                     cfg_sleep,
  input  logic [PRE_W-1:0]         cfg_prescale,
  input  logic [SU_W-1:0]          cfg_startup,
  input  logic [SH_W-1:0]          cfg_shtime,
  input  logic [N_CH-1:0]          ch_enable,
  input  logic [N_TMR-1:0]         tmr_trig,
  input  logic                     ext_trig,
  input  logic                     cv_done,
  input  logic [DATA_W-1:0]        cv_data,
  output logic                     cv_start,
  output logic [$clog2(N_CH)-1:0]  cv_chan,
  output logic                     res_valid,
  output logic [$clog2(N_CH)-1:0]  res_chan,
  output logic [DATA_W-1:0]        res_data,
  output logic                     res_low_res,
  output logic                     eoc_clear,
  output logic                     busy,
  output logic                     powered
);
  logic hw_fire;
  logic go;
  logic tick;
  logic run;

  assign go = start_req || hw_fire;

  adc_trig_pick #(
    .N_TMR (N_TMR),
    .SEL_W (SEL_W)
  ) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (soft_reset),
    .trig_en  (cfg_trig_en),
    .trig_sel (cfg_trig_sel),
    .tmr_trig (tmr_trig),
    .ext_trig (ext_trig),
    .fire     (hw_fire)
  );

  adc_tick_gen #(
    .PRE_W (PRE_W)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (soft_reset),
    .run      (run),
    .prescale (cfg_prescale),
    .tick     (tick)
  );

  adc_seq_fsm #(
    .N_CH   (N_CH),
    .DATA_W (DATA_W),
    .SU_W   (SU_W),
    .SH_W   (SH_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst        (soft_reset),
    .go          (go),
    .tick        (tick),
    .cfg_sleep   (cfg_sleep),
    .cfg_low_res (cfg_low_res),
    .cfg_startup (cfg_startup),
    .cfg_shtime  (cfg_shtime),
    .ch_enable   (ch_enable),
    .cv_done     (cv_done),
    .cv_data     (cv_data),
    .run         (run),
    .cv_start    (cv_start),
    .cv_chan     (cv_chan),
    .res_valid   (res_valid),
    .res_chan    (res_chan),
    .res_data    (res_data),
    .res_low_res (res_low_res),
    .eoc_clear   (eoc_clear),
    .busy        (busy),
    .powered     (powered)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_reset,
  input logic              cv_start,
  input logic              cv_done,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              res_low_res,
  input logic              eoc_clear,
  input logic              busy,
  input logic              powered
);
  AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cv_start |=> !cv_start); // R6

  AST_RESULT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cv_done)); // R6

  AST_LOWRES_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_low_res) |-> (res_data[DATA_W-1 -: 2] == 2'b00)); // R8

  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> eoc_clear); // R5

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_clear |-> !$past(busy)); // R7

  AST_LAUNCH_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    cv_start |-> powered); // R9

  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (!busy && !cv_start)); // R10
endmodule

bind adc_seq_ctrl adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_reset  (soft_reset),
  .cv_start    (cv_start),
  .cv_done     (cv_done),
  .res_valid   (res_valid),
  .res_data    (res_data),
  .res_low_res (res_low_res),
  .eoc_clear   (eoc_clear),
  .busy        (busy),
  .powered     (powered)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       soft_reset;
  logic       start_req;
  logic       cfg_trig_en;
  logic [2:0] cfg_trig_sel;
  logic       cfg_low_res;
  logic       cfg_sleep;
  logic [5:0] cfg_prescale;
  logic [4:0] cfg_startup;
  logic [3:0] cfg_shtime;
  logic [7:0] ch_enable;
  logic [5:0] tmr_trig;
  logic       ext_trig;
  logic       cv_done;
  logic [9:0] cv_data;
  logic       cv_start;
  logic [2:0] cv_chan;
  logic       res_valid;
  logic [2:0] res_chan;
  logic [9:0] res_data;
  logic       res_low_res;
  logic       eoc_clear;
  logic       busy;
  logic       powered;

  int errors = 0;
  int checks = 0;
  int seq_id = 0;
  int nres   = 0;
  int neoc   = 0;
  bit warm   = 0;
  bit ended  = 0;
  logic [2:0] log_ch [16];
  logic [9:0] log_d  [16];
  logic       log_lr [16];

  typedef struct packed {
    logic [5:0] p;
    logic [4:0] s;
    logic [3:0] h;
    logic [7:0] m;
    logic       lr;
    logic       sl;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{6'd0, 5'd0, 4'd0, 8'h01, 1'b0, 1'b0},
    '{6'd1, 5'd3, 4'd2, 8'hA6, 1'b0, 1'b0},
    '{6'd3, 5'd0, 4'd0, 8'hFF, 1'b1, 1'b0},
    '{6'd0, 5'd1, 4'd1, 8'h80, 1'b0, 1'b1},
    '{6'd2, 5'd0, 4'd3, 8'h51, 1'b1, 1'b1},
    '{6'd0, 5'd0, 4'd0, 8'h18, 1'b0, 1'b0}
  };

  adc_seq_ctrl u_dut (
    .clk, .rst_n, .soft_reset, .start_req, .cfg_trig_en, .cfg_trig_sel,
    .cfg_low_res, .cfg_sleep, .cfg_prescale, .cfg_startup, .cfg_shtime,
    .ch_enable, .tmr_trig, .ext_trig, .cv_done, .cv_data, .cv_start,
    .cv_chan, .res_valid, .res_chan, .res_data, .res_low_res, .eoc_clear,
    .busy, .powered
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [9:0] conv_val(input int sq, input int ch);
    return 10'((ch * 83 + sq * 149 + 17) % 1024);
  endfunction

  function automatic logic [9:0] shaped(input logic [9:0] v, input logic lr);
    return lr ? {2'b00, v[9:2]} : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: answers each launch three cycles later
  initial begin
    cv_done = 1'b0;
    cv_data = '0;
    forever begin
      @(negedge clk);
      if (cv_start) begin
        automatic int ch = int'(cv_chan);
        repeat (3) @(negedge clk);
        cv_data = conv_val(seq_id, ch);
        cv_done = 1'b1;
        @(negedge clk);
        cv_done = 1'b0;
      end
    end
  end

  // result and clear-pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (nres < 16) begin
          log_ch[nres] = res_chan;
          log_d[nres]  = res_data;
          log_lr[nres] = res_low_res;
        end
        nres++;
      end
      if (eoc_clear) neoc++;
    end
  end

  task automatic set_cfg(input vec_t v);
    cfg_prescale = v.p;
    cfg_startup  = v.s;
    cfg_shtime   = v.h;
    ch_enable    = v.m;
    cfg_low_res  = v.lr;
    cfg_sleep    = v.sl;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin
      @(negedge clk);
      g++;
    end
    repeat (8) @(negedge clk);
  endtask

  // pulse start at a negedge and return the latency in cycles to cv_start
  task automatic start_and_measure(output int lat);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    lat = 0;
    while (!cv_start && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_reset = 1'b0; start_req = 1'b0;
    cfg_trig_en = 1'b0; cfg_trig_sel = 3'd0;
    tmr_trig = '0; ext_trig = 1'b0;
    set_cfg(VEC[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check(busy == 1'b0, "R11 busy", int'(busy), 0);
    check(cv_start == 1'b0 && res_valid == 1'b0, "R11 cv_start/res_valid", int'({cv_start, res_valid}), 0);
    check(eoc_clear == 1'b0, "R11 eoc_clear", int'(eoc_clear), 0);

    // table-driven sequences
    for (int i = 0; i < 6; i++) begin
      automatic vec_t v = VEC[i];
      automatic int lat;
      automatic int d = (int'(v.p) + 1) * 2;
      automatic bit need_wake = v.sl || !warm;
      automatic int exp_lat = ((need_wake ? (int'(v.s) + 1) * 8 : 0) + int'(v.h) + 1) * d;
      automatic int e0 = neoc;
      automatic int k = 0;
      seq_id = i;
      nres = 0;
      set_cfg(v);
      start_and_measure(lat);
      // R1 R2 R3 R9: latency made of whole ticks, with or without startup
      check(lat == exp_lat, need_wake ? "R2 R1 launch latency with startup" : "R3 R1 launch latency hold only",
            lat, exp_lat);
      wait_idle();
      check(neoc == e0 + 1, "R5 one clear pulse", neoc - e0, 1);
      check(nres == $countones(v.m), "R6 result count", nres, $countones(v.m));
      for (int ch = 0; ch < 8; ch++) begin
        if (v.m[ch] && k < 16) begin
          check(log_ch[k] == 3'(ch), "R6 channel order", int'(log_ch[k]), ch);
          check(log_d[k] == shaped(conv_val(i, ch), v.lr), "R8 result data",
                int'(log_d[k]), int'(shaped(conv_val(i, ch), v.lr)));
          check(log_lr[k] == v.lr, "R8 resolution flag", int'(log_lr[k]), int'(v.lr));
          k++;
        end
      end
      check(powered == !v.sl, "R9 idle power", int'(powered), int'(!v.sl));
      warm = !v.sl;
    end

    // R4: hardware trigger disabled
    set_cfg('{6'd0, 5'd0, 4'd0, 8'h01, 1'b0, 1'b0});
    cfg_trig_en = 1'b0; cfg_trig_sel = 3'd2;
    tmr_trig = 6'b000100;
    begin
      automatic bit seen = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (busy) seen = 1;
      end
      check(!seen, "R4 trigger disabled ignored", int'(seen), 0);
    end
    tmr_trig = '0;
    @(negedge clk);

    // R4: timer source 2 accepted at the same edge as a start request
    cfg_trig_en = 1'b1;
    tmr_trig = 6'b000100;
    @(negedge clk);
    check(busy == 1'b1, "R4 timer trigger", int'(busy), 1);
    tmr_trig = '0;
    wait_idle();

    // R4: external source, two extra edges through the synchronizer
    cfg_trig_sel = 3'd6;
    ext_trig = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R4 external not yet", int'(busy), 0);
    @(negedge clk);
    check(busy == 1'b1, "R4 external accepted", int'(busy), 1);
    ext_trig = 1'b0;
    wait_idle();

    // R4: selector value 7 has no source
    cfg_trig_sel = 3'd7;
    tmr_trig = 6'h3F; ext_trig = 1'b1;
    begin
      automatic bit seen = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (busy) seen = 1;
      end
      check(!seen, "R4 selector 7 ignored", int'(seen), 0);
    end
    tmr_trig = '0; ext_trig = 1'b0;
    cfg_trig_en = 1'b0;
    repeat (4) @(negedge clk);

    // R7: start while busy is ignored
    begin
      automatic int lat;
      automatic int e0 = neoc;
      set_cfg('{6'd0, 5'd0, 4'd0, 8'h03, 1'b0, 1'b0});
      nres = 0;
      start_and_measure(lat);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      wait_idle();
      check(neoc == e0 + 1, "R7 no second clear", neoc - e0, 1);
      check(nres == 2, "R7 no extra results", nres, 2);
    end

    // R10: soft reset aborts and forgets warm-up
    begin
      automatic int lat;
      set_cfg('{6'd0, 5'd0, 4'd2, 8'h01, 1'b0, 1'b0});
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (2) @(negedge clk);
      check(busy == 1'b1, "R10 running before reset", int'(busy), 1);
      soft_reset = 1'b1;
      @(negedge clk);
      soft_reset = 1'b0;
      check(busy == 1'b0, "R10 aborted", int'(busy), 0);
      repeat (8) @(negedge clk);
      set_cfg('{6'd0, 5'd0, 4'd0, 8'h01, 1'b0, 1'b0});
      start_and_measure(lat);
      check(lat == 18, "R10 startup repeated", lat, 18);
      wait_idle();
    end

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule